// File: doc/BRIEF.md
# Signed Multiply-Add Unit

This block performs the signed integer multiplies of a 64-bit fixed-point datapath. A caller presents two register operands, an optional addend, a 16-bit immediate and an operation code, then pulses `start`. The unit forms a full 128-bit two's-complement product over a fixed number of cycles and returns a 64-bit result. The result is one half of the product, the product's upper word in the low 32 bits, or one half of the product plus a sign-extended addend.

A single radix-4 Booth engine serves every operation. Word operations sign-extend the low 32 bits of each source into the same 64-bit engine. The immediate form substitutes the sign-extended immediate for the second operand. The multiply-add forms preload the 128-bit accumulator with the sign-extended addend, so the addition costs no extra cycle. A job runs for WIDTH/2 iterations. While it runs `busy` is high and further `start` pulses are ignored. `done` pulses for one cycle when `result` is updated.

Top module: `mul_add_unit`

## Requirements
- R1: Operation code 0 returns bits 63:0 of the signed 128-bit product of `srcA` and `srcB`.
- R2: Operation code 1 returns bits 127:64 of the signed 128-bit product of `srcA` and `srcB`.
- R3: Operation code 2 multiplies the signed low 32 bits of `srcA` and `srcB`. It returns the upper 32 bits of that 64-bit product in `result[31:0]` and drives `result[63:32]` to zero.
- R4: Operation code 3 returns the whole signed 64-bit product of the low 32 bits of `srcA` and `srcB`. Bits 63:32 of the sources have no effect.
- R5: Operation code 4 sign-extends `imm` to 64 bits, multiplies it by `srcA` as signed values, and returns bits 63:0 of the product. `srcB` has no effect.
- R6: Operation code 5 adds `srcC`, sign-extended to 128 bits, to the signed 128-bit product of `srcA` and `srcB`, and returns bits 127:64 of the sum.
- R7: Operation code 6 forms the same sum as R6 and returns bits 63:0 of it.
- R8: A `start` seen while `busy` is low is accepted. `busy` is high from the next cycle until `done` rises. `done` rises exactly WIDTH/2 (32) cycles after the accepting edge and lasts one cycle.
- R9: A `start` seen while `busy` is high is ignored, and operands and operation code are sampled only at the accepting edge. No extra `done` is produced.
- R10: After reset `busy`, `done` and `result` are zero. `result` changes only on a cycle where `done` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new operation |
| opSel | input | 3 | Operation code (0..6, see requirements) |
| srcA | input | 64 | First signed operand |
| srcB | input | 64 | Second signed operand |
| srcC | input | 64 | Signed addend for multiply-add |
| imm | input | 16 | Signed immediate for multiply-immediate |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle pulse: `result` just updated |
| result | output | 64 | Selected result |

## Verification
The assertions follow the handshake on every cycle. They check that `busy` follows an accepted start, that `done` is a single-cycle pulse arriving exactly WIDTH/2 busy cycles after acceptance, that `result` moves only with `done`, and that the high-word form leaves the upper 32 bits clear. The arithmetic can only be shown by the bench's scenarios. These pair each job with a product computed independently in the bench. They cover sign extremes, negative immediates and addends, and word operands with noisy upper halves. Further scenarios fire `start` with unrelated operands in the middle of a job to show that these are ignored.

// File: rtl/mad_pkg.sv
package mad_pkg;

  typedef enum logic [2:0] {
    OP_MUL_LO   = 3'd0,
    OP_MUL_HI   = 3'd1,
    OP_WORD_HI  = 3'd2,
    OP_WORD_ALL = 3'd3,
    OP_MUL_IMM  = 3'd4,
    OP_MADD_HI  = 3'd5,
    OP_MADD_LO  = 3'd6
  } madOp_e;

  // Strobes from the sequencer to the arithmetic path
  typedef struct packed {
    logic load;    // capture operands, preload accumulator
    logic step;    // retire one Booth digit
    logic finish;  // final digit: capture the selected result
  } madStrobe_t;

  // Result placement chosen per operation
  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_WORD = 2'd2
  } madSel_e;

  function automatic madSel_e pickSel(input madOp_e op);
    case (op)
      OP_MUL_HI, OP_MADD_HI: pickSel = SEL_HIGH;
      OP_WORD_HI:            pickSel = SEL_WORD;
      default:               pickSel = SEL_LOW;
    endcase
  endfunction

endpackage

// File: rtl/mad_ctrl.sv
module mad_ctrl
  import mad_pkg::*;
#(
  parameter int ITERS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output madStrobe_t strb,
  output logic       busy,
  output logic       done
);

  localparam int CNT_W = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ITERS - 1);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_e;

  ctrlState_e       state;
  logic [CNT_W-1:0] digitCnt;
  logic             doneReg;

  always_comb begin
    strb.load   = (state == ST_IDLE) && start;
    strb.step   = (state == ST_RUN);
    strb.finish = (state == ST_RUN) && (digitCnt == LAST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      digitCnt <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= strb.finish;
      case (state)
        ST_IDLE: begin
          digitCnt <= '0;
          if (strb.load) state <= ST_RUN;
        end
        ST_RUN: begin
          if (strb.finish) begin
            state    <= ST_IDLE;
            digitCnt <= '0;
          end else begin
            digitCnt <= digitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_RUN);
  assign done = doneReg;

endmodule

// File: rtl/mad_dpath.sv
module mad_dpath
  import mad_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  madStrobe_t       strb,
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [WIDTH-1:0] srcC,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] result
);

  localparam int PROD_W = 2 * WIDTH;
  localparam int HALF_W = WIDTH / 2;

  madOp_e            opReg;
  logic [PROD_W-1:0] mcand;   // multiplicand, shifted left two per digit
  logic [WIDTH:0]    mplier;  // multiplier with the implicit zero below bit 0
  logic [PROD_W-1:0] acc;
  logic [WIDTH-1:0]  resReg;

  // Operand preparation for the load cycle
  logic [WIDTH-1:0]  opA, opB;
  logic [PROD_W-1:0] addend;
  madOp_e            opIn;

  assign opIn = madOp_e'(opSel);

  always_comb begin
    opA    = srcA;
    opB    = srcB;
    addend = '0;
    case (opIn)
      OP_WORD_HI, OP_WORD_ALL: begin
        opA = {{(WIDTH-HALF_W){srcA[HALF_W-1]}}, srcA[HALF_W-1:0]};
        opB = {{(WIDTH-HALF_W){srcB[HALF_W-1]}}, srcB[HALF_W-1:0]};
      end
      OP_MUL_IMM: opB = {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm};
      OP_MADD_HI, OP_MADD_LO: addend = {{WIDTH{srcC[WIDTH-1]}}, srcC};
      default: ;
    endcase
  end

  // Radix-4 Booth digit from the three low multiplier bits
  logic [PROD_W-1:0] partial;
  logic [PROD_W-1:0] nextAcc;

  always_comb begin
    case (mplier[2:0])
      3'b001, 3'b010: partial = mcand;
      3'b011:         partial = mcand << 1;
      3'b100:         partial = -(mcand << 1);
      3'b101, 3'b110: partial = -mcand;
      default:        partial = '0;
    endcase
    nextAcc = acc + partial;
  end

  // Result placement
  logic [WIDTH-1:0] selected;

  always_comb begin
    case (pickSel(opReg))
      SEL_HIGH: selected = nextAcc[PROD_W-1:WIDTH];
      SEL_WORD: selected = {{(WIDTH-HALF_W){1'b0}}, nextAcc[WIDTH-1:HALF_W]};
      default:  selected = nextAcc[WIDTH-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opReg  <= OP_MUL_LO;
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      resReg <= '0;
    end else if (strb.load) begin
      opReg  <= opIn;
      mcand  <= {{WIDTH{opA[WIDTH-1]}}, opA};
      mplier <= {opB, 1'b0};
      acc    <= addend;
    end else if (strb.step) begin
      acc    <= nextAcc;
      mcand  <= mcand << 2;
      mplier <= {{2{mplier[WIDTH]}}, mplier[WIDTH:2]};
      if (strb.finish) resReg <= selected;
    end
  end

  assign result = resReg;

endmodule

// File: rtl/mul_add_unit.sv
module mul_add_unit
  import mad_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       opSel,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  input  logic [WIDTH-1:0] srcC,
  input  logic [IMM_W-1:0] imm,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result
);

  localparam int ITERS = WIDTH / 2;

  madStrobe_t strb;

  mad_ctrl #(.ITERS(ITERS)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  mad_dpath #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .opSel  (opSel),
    .srcA   (srcA),
    .srcB   (srcB),
    .srcC   (srcC),
    .imm    (imm),
    .result (result)
  );

endmodule

// File: rtl/mad_chk.sv
module mad_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2:0]       opSel,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] result
);

  localparam int ITERS = WIDTH / 2;

  int unsigned busyCnt;
  logic [2:0]  jobOp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyCnt <= 0;
      jobOp   <= 3'd0;
    end else begin
      busyCnt <= busy ? busyCnt + 1 : 0;
      if (start && !busy) jobOp <= opSel;
    end
  end

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |=> busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busyCnt == ITERS) && !busy);

  // R9
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busyCnt < ITERS);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R3
  word_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && jobOp == 3'd2) |-> (result[WIDTH-1:WIDTH/2] == '0));

endmodule

bind mul_add_unit mad_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .opSel  (opSel),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/mul_add_unit_test.sv
module mul_add_unit_test;

  localparam int LAT = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = '0;
  logic [63:0] srcA = '0, srcB = '0, srcC = '0;
  logic [15:0] imm = '0;
  logic        busy, done;
  logic [63:0] result;

  always #2 clk = ~clk;  // 250 MHz

  mul_add_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .srcC(srcC), .imm(imm),
    .busy(busy), .done(done), .result(result)
  );

  typedef struct {
    logic [63:0] val;
    logic [2:0]  op;
    int          acceptCyc;
  } item_t;

  item_t       expQ[$];
  int          cyc = 0;
  int          checks = 0;
  int          bad = 0;
  logic [63:0] lastRes = '0;
  bit          ended = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: reqOf = "R1";
      3'd1: reqOf = "R2";
      3'd2: reqOf = "R3";
      3'd3: reqOf = "R4";
      3'd4: reqOf = "R5";
      3'd5: reqOf = "R6";
      default: reqOf = "R7";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b, input logic [63:0] c,
                                        input logic [15:0] im);
    logic signed [127:0] x, y, p;
    x = {{64{a[63]}}, a};
    y = {{64{b[63]}}, b};
    if (op == 3'd2 || op == 3'd3) begin
      x = {{96{a[31]}}, a[31:0]};
      y = {{96{b[31]}}, b[31:0]};
    end
    if (op == 3'd4) y = {{112{im[15]}}, im};
    p = x * y;
    if (op == 3'd5 || op == 3'd6) p = p + {{64{c[63]}}, c};
    case (op)
      3'd1, 3'd5: model = p[127:64];
      3'd2:       model = {32'h0, p[63:32]};
      default:    model = p[63:0];
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // Driver: issue one job, optionally spray ignored starts while it runs
  task automatic runJob(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] c, input logic [15:0] im, input bit noise);
    item_t it;
    @(negedge clk);
    while (busy || done) @(negedge clk);
    opSel = op; srcA = a; srcB = b; srcC = c; imm = im; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    it.val = model(op, a, b, c, im);
    it.op = op;
    it.acceptCyc = cyc;
    expQ.push_back(it);
    check(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
    if (noise) begin
      for (int i = 0; i < 6; i++) begin
        start = 1'b1;
        opSel = 3'($urandom_range(0, 6));
        srcA = {$urandom, $urandom}; srcB = {$urandom, $urandom};
        srcC = {$urandom, $urandom}; imm = 16'($urandom);
        @(negedge clk);
      end
      start = 1'b0;
    end
  endtask

  // Monitor: compare each completion against the scoreboard
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected done", result, 64'h0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(result == it.val, reqOf(it.op), result, it.val);
          check(cyc - it.acceptCyc == LAT, "R8 latency", 64'(cyc - it.acceptCyc), 64'(LAT));
        end
        lastRes = result;
      end else begin
        // R10: result holds between completions
        check(result == lastRes, "R10 hold", result, lastRes);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 64'(cyc), 64'h0);
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    check(busy == 1'b0, "R10 busy reset", 64'(busy), 64'd0);
    check(done == 1'b0, "R10 done reset", 64'(done), 64'd0);
    check(result == 64'h0, "R10 result reset", result, 64'h0);

    // R1 / R2: doubleword halves, sign extremes
    runJob(3'd0, 64'd7, 64'd9, 64'd0, 16'd0, 0);
    runJob(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5, 64'd0, 16'd0, 0);
    runJob(3'd1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'd0, 16'd0, 0);
    runJob(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 64'd0, 16'd0, 0);
    runJob(3'd1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 16'd0, 0);
    // R3 / R4: word forms with noisy upper halves
    runJob(3'd2, 64'hDEAD_BEEF_8000_0000, 64'h1234_5678_8000_0000, 64'd0, 16'd0, 0);
    runJob(3'd2, 64'hAAAA_AAAA_FFFF_FFFE, 64'h5555_5555_0000_0003, 64'd0, 16'd0, 0);
    runJob(3'd3, 64'hFFFF_0000_FFFF_FFFF, 64'h0F0F_0F0F_7FFF_FFFF, 64'd0, 16'd0, 0);
    // R5: immediate, srcB is garbage
    runJob(3'd4, 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h8000, 0);
    runJob(3'd4, 64'h8000_0000_0000_0001, 64'h1234, 64'd0, 16'h7FFF, 0);
    // R6 / R7: multiply-add with negative addend
    runJob(3'd5, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 16'd0, 0);
    runJob(3'd6, 64'd1000, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8000_0000_0000_0000, 16'd0, 0);
    runJob(3'd5, 64'h4000_0000_0000_0000, 64'd4, 64'd0, 16'd0, 0);
    // R9: starts during busy are ignored
    runJob(3'd0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'd0, 16'd0, 1);
    runJob(3'd6, 64'hCAFE_F00D_0000_1111, 64'h7, 64'h1, 16'd0, 1);
    // Mixed patterns
    for (int k = 0; k < 24; k++) begin
      runJob(3'(k % 7), {$urandom, $urandom}, {$urandom, $urandom},
             {$urandom, $urandom}, 16'($urandom), k[2]);
    end
    @(negedge clk);
    while (busy || done || expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
  end

endmodule